// File: doc/BRIEF.md
# Configuration Request Router

This block sits between a host-side configuration request port and two destinations: the internal bus-0 devices and a downstream serial link. Each request carries a dword-aligned address word that holds the extended register number, bus, device, function and register number, plus a write flag, write data and byte enables. The block compares the bus number against two programmable bus numbers, the secondary and the subordinate bus, and sends the request in one of four directions. It may go to an internal device on bus 0. It may become a Type 0 configuration header for the device just across the link, or a Type 1 header for a bus further downstream. Otherwise it is ended at once with a master abort.

For forwarded requests the block packs the routing bytes (header bytes 8 to 11) into one 32-bit word and offers it on a valid/ready port. It then waits for a completion before it answers the requester. Only one request is in flight at any time. The request port stays busy from acceptance until a one-cycle response pulse has been returned.

Top module: `cfg_route_top`

## Requirements
- R1: After reset `req_ready` is 1 and `hdr_valid`, `int_req_valid` and `rsp_valid` are 0. The secondary and subordinate bus numbers are 0, so a request to any non-zero bus ends in a master abort.
- R2: A request on bus 0 to a device whose bit is set both in parameter `INT_DEV_MAP` and in input `int_dev_en` raises `int_req_valid` with the device, function, `{ext,reg}`, write flag, data and byte enables. It is held until `int_cpl_valid`. The response then carries status 0 (OK) and, for reads, `int_cpl_rdata`.
- R3: A request on bus 0 to a device that is absent from `INT_DEV_MAP` or cleared in `int_dev_en` is not claimed and ends with status 1 (master abort).
- R4: A request whose bus equals the secondary bus and whose device is 0 produces a header with `hdr_type1` = 0.
- R5: A request whose bus equals the secondary bus and whose device is not 0 produces no header and ends with status 1.
- R6: A request whose bus is above the secondary bus and not above the subordinate bus produces a header with `hdr_type1` = 1.
- R7: A request on a non-zero bus that matches neither R4/R5 nor R6 ends with status 1. An aborted read returns 32'hFFFF_FFFF and an aborted write returns 0.
- R8: `hdr_bytes[31:24]` is byte 8 = bus. `hdr_bytes[23:16]` is byte 9 = {device[4:0], function[2:0]}. `hdr_bytes[15:8]` is byte 10 = {4'b0, ext[3:0]}. `hdr_bytes[7:0]` is byte 11 = {reg[5:0], 2'b00}.
- R9: Forwarded writes, extended registers included, are non-posted. `hdr_write`, `hdr_wdata` and `hdr_be` carry the request, and no response is given until a completion (`cpl_valid`) is taken.
- R10: `req_ready` is 0 from the cycle after acceptance through the response cycle, and 1 again in the cycle after the response.
- R11: While `hdr_valid` is 1 and `hdr_ready` is 0, the header and its type stay unchanged.
- R12: A completion with `cpl_err` = 1 yields status 2 (completer error), and a read then returns 32'hFFFF_FFFF. A good read completion returns `cpl_rdata`.
- R13: `rsp_valid` is a one-cycle pulse. For an abort it comes in the cycle after acceptance. For a claimed or forwarded request it comes in the cycle after the completion handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_load | input | 1 | Load secondary/subordinate bus numbers |
| bus_sec_in | input | 8 | Secondary bus number to load |
| bus_sub_in | input | 8 | Subordinate bus number to load |
| int_dev_en | input | 32 | Per-device enable of internal bus-0 devices |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Bits [27:2]: ext [27:24], bus [23:16], device [15:11], function [10:8], register [7:2] |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| int_req_valid | output | 1 | Request to internal device |
| int_req_write | output | 1 | Internal request is a write |
| int_req_dev | output | 5 | Internal device number |
| int_req_fn | output | 3 | Internal function number |
| int_req_reg | output | 10 | {ext, register} |
| int_req_wdata | output | 32 | Internal write data |
| int_req_be | output | 4 | Internal byte enables |
| int_cpl_valid | input | 1 | Internal device done |
| int_cpl_rdata | input | 32 | Internal read data |
| hdr_valid | output | 1 | Header offered |
| hdr_ready | input | 1 | Header taken |
| hdr_type1 | output | 1 | 0 = Type 0, 1 = Type 1 |
| hdr_write | output | 1 | Header is a configuration write |
| hdr_bytes | output | 32 | Header bytes 8..11 |
| hdr_wdata | output | 32 | Write payload |
| hdr_be | output | 4 | Byte enables |
| cpl_valid | input | 1 | Link completion arrived |
| cpl_err | input | 1 | Completion reports an error |
| cpl_rdata | input | 32 | Completion read data |
| rsp_valid | output | 1 | Response pulse to requester |
| rsp_status | output | 2 | 0 OK, 1 master abort, 2 completer error |
| rsp_rdata | output | 32 | Response read data |

## Verification
Every path has a fixed latency counted in registers. A header or an internal request is visible in the cycle after acceptance. An abort response appears in that same cycle. A response for a claimed or forwarded request appears in the cycle after `int_cpl_valid` or `cpl_valid` is sampled. The directed tasks drive inputs just after a rising edge, step exactly that many edges, and sample on the falling edge. Absence is checked in the same way: the bench looks at the falling edges where a header or response must not appear, for example while a write waits for its completion or while the header is stalled.

// File: rtl/cfgrt_pkg.sv
package cfgrt_pkg;
    parameter int BUS_W  = 8;
    parameter int DEV_W  = 5;
    parameter int FN_W   = 3;
    parameter int REG_W  = 6;
    parameter int EXT_W  = 4;
    parameter int DATA_W = 32;
    parameter int BE_W   = DATA_W / 8;
    parameter int NDEV   = 1 << DEV_W;

    // address word field positions (dword aligned, bits [1:0] absent)
    parameter int A_REG_LO = 2;
    parameter int A_FN_LO  = A_REG_LO + REG_W;
    parameter int A_DEV_LO = A_FN_LO + FN_W;
    parameter int A_BUS_LO = A_DEV_LO + DEV_W;
    parameter int A_EXT_LO = A_BUS_LO + BUS_W;
    parameter int A_HI     = A_EXT_LO + EXT_W - 1;

    typedef enum logic [1:0] {
        RT_INT   = 2'd0,
        RT_T0    = 2'd1,
        RT_T1    = 2'd2,
        RT_ABORT = 2'd3
    } route_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_INT  = 3'd1,
        ST_HDR  = 3'd2,
        ST_WAIT = 3'd3,
        ST_RESP = 3'd4
    } state_e;

    parameter logic [1:0] RS_OK = 2'd0;
    parameter logic [1:0] RS_MA = 2'd1;
    parameter logic [1:0] RS_CE = 2'd2;

    typedef struct packed {
        state_e              st;
        logic                wr;
        logic [BUS_W-1:0]    bus;
        logic [DEV_W-1:0]    dev;
        logic [FN_W-1:0]     fn;
        logic [REG_W-1:0]    rg;
        logic [EXT_W-1:0]    ext;
        logic [DATA_W-1:0]   wdata;
        logic [BE_W-1:0]     be;
        logic                t1;
        logic [1:0]          status;
        logic [DATA_W-1:0]   rdata;
    } ctx_t;
endpackage

// File: rtl/cfgrt_busregs.sv
module cfgrt_busregs
    import cfgrt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] sec_in,
    input  logic [BUS_W-1:0] sub_in,
    output logic [BUS_W-1:0] sec_q,
    output logic [BUS_W-1:0] sub_q
);
    localparam int NREG = 2;

    logic [NREG-1:0][BUS_W-1:0] val_d, val_q;
    logic [NREG-1:0][BUS_W-1:0] src;

    assign src[0] = sec_in;
    assign src[1] = sub_in;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_comb begin
            val_d[i] = load ? src[i] : val_q[i];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q[i] <= '0;
            else        val_q[i] <= val_d[i];
        end
    end

    assign sec_q = val_q[0];
    assign sub_q = val_q[1];
endmodule

// File: rtl/cfgrt_route.sv
module cfgrt_route
    import cfgrt_pkg::*;
(
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [BUS_W-1:0] sec,
    input  logic [BUS_W-1:0] sub,
    input  logic [NDEV-1:0]  claim_map,
    output route_e           route
);
    logic on_bus0, on_sec, below_sub, above_sec;

    always_comb begin
        on_bus0   = (bus == '0);
        on_sec    = (bus == sec);
        above_sec = (bus > sec);
        below_sub = (bus <= sub);
        if (on_bus0) begin
            route = claim_map[dev] ? RT_INT : RT_ABORT;
        end else if (on_sec) begin
            route = (dev == '0) ? RT_T0 : RT_ABORT;
        end else if (above_sec && below_sub) begin
            route = RT_T1;
        end else begin
            route = RT_ABORT;
        end
    end
endmodule

// File: rtl/cfgrt_hdr_pack.sv
module cfgrt_hdr_pack
    import cfgrt_pkg::*;
(
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    input  logic [EXT_W-1:0] ext,
    input  logic [REG_W-1:0] rg,
    output logic [31:0]      bytes
);
    localparam int B10_PAD = 8 - EXT_W;
    localparam int B11_PAD = 8 - REG_W;

    logic [7:0] b8, b9, b10, b11;

    always_comb begin
        b8    = bus;
        b9    = {dev, fn};
        b10   = {{B10_PAD{1'b0}}, ext};
        b11   = {rg, {B11_PAD{1'b0}}};
        bytes = {b8, b9, b10, b11};
    end
endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
    import cfgrt_pkg::*;
#(
    parameter logic [31:0] INT_DEV_MAP = 32'h0000_0005
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_load,
    input  logic [7:0]           bus_sec_in,
    input  logic [7:0]           bus_sub_in,
    input  logic [31:0]          int_dev_en,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [27:2]          req_addr,
    input  logic [31:0]          req_wdata,
    input  logic [3:0]           req_be,
    output logic                 int_req_valid,
    output logic                 int_req_write,
    output logic [4:0]           int_req_dev,
    output logic [2:0]           int_req_fn,
    output logic [9:0]           int_req_reg,
    output logic [31:0]          int_req_wdata,
    output logic [3:0]           int_req_be,
    input  logic                 int_cpl_valid,
    input  logic [31:0]          int_cpl_rdata,
    output logic                 hdr_valid,
    input  logic                 hdr_ready,
    output logic                 hdr_type1,
    output logic                 hdr_write,
    output logic [31:0]          hdr_bytes,
    output logic [31:0]          hdr_wdata,
    output logic [3:0]           hdr_be,
    input  logic                 cpl_valid,
    input  logic                 cpl_err,
    input  logic [31:0]          cpl_rdata,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_status,
    output logic [31:0]          rsp_rdata
);
    localparam ctx_t CTX_RST = '0;

    logic [BUS_W-1:0] sec_q, sub_q;
    logic [BUS_W-1:0] a_bus;
    logic [DEV_W-1:0] a_dev;
    logic [FN_W-1:0]  a_fn;
    logic [REG_W-1:0] a_rg;
    logic [EXT_W-1:0] a_ext;
    logic [NDEV-1:0]  claim_map;
    route_e           route;
    ctx_t             ctx_d, ctx_q;

    assign a_rg  = req_addr[A_FN_LO-1:A_REG_LO];
    assign a_fn  = req_addr[A_DEV_LO-1:A_FN_LO];
    assign a_dev = req_addr[A_BUS_LO-1:A_DEV_LO];
    assign a_bus = req_addr[A_EXT_LO-1:A_BUS_LO];
    assign a_ext = req_addr[A_HI:A_EXT_LO];
    assign claim_map = INT_DEV_MAP & int_dev_en;

    cfgrt_busregs u_busregs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (bus_load),
        .sec_in (bus_sec_in),
        .sub_in (bus_sub_in),
        .sec_q  (sec_q),
        .sub_q  (sub_q)
    );

    cfgrt_route u_route (
        .bus       (a_bus),
        .dev       (a_dev),
        .sec       (sec_q),
        .sub       (sub_q),
        .claim_map (claim_map),
        .route     (route)
    );

    cfgrt_hdr_pack u_pack (
        .bus   (ctx_q.bus),
        .dev   (ctx_q.dev),
        .fn    (ctx_q.fn),
        .ext   (ctx_q.ext),
        .rg    (ctx_q.rg),
        .bytes (hdr_bytes)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.wr     = req_write;
                    ctx_d.bus    = a_bus;
                    ctx_d.dev    = a_dev;
                    ctx_d.fn     = a_fn;
                    ctx_d.rg     = a_rg;
                    ctx_d.ext    = a_ext;
                    ctx_d.wdata  = req_wdata;
                    ctx_d.be     = req_be;
                    ctx_d.t1     = (route == RT_T1);
                    ctx_d.status = RS_OK;
                    ctx_d.rdata  = '0;
                    unique case (route)
                        RT_INT:  ctx_d.st = ST_INT;
                        RT_T0,
                        RT_T1:   ctx_d.st = ST_HDR;
                        default: begin
                            ctx_d.st     = ST_RESP;
                            ctx_d.status = RS_MA;
                            ctx_d.rdata  = req_write ? '0 : '1;
                        end
                    endcase
                end
            end
            ST_INT: begin
                if (int_cpl_valid) begin
                    ctx_d.rdata = ctx_q.wr ? '0 : int_cpl_rdata;
                    ctx_d.st    = ST_RESP;
                end
            end
            ST_HDR: begin
                if (hdr_ready) ctx_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (cpl_valid) begin
                    ctx_d.st     = ST_RESP;
                    ctx_d.status = cpl_err ? RS_CE : RS_OK;
                    if (ctx_q.wr)     ctx_d.rdata = '0;
                    else if (cpl_err) ctx_d.rdata = '1;
                    else              ctx_d.rdata = cpl_rdata;
                end
            end
            ST_RESP: ctx_d.st = ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= CTX_RST;
        else        ctx_q <= ctx_d;
    end

    assign req_ready     = (ctx_q.st == ST_IDLE);
    assign int_req_valid = (ctx_q.st == ST_INT);
    assign int_req_write = ctx_q.wr;
    assign int_req_dev   = ctx_q.dev;
    assign int_req_fn    = ctx_q.fn;
    assign int_req_reg   = {ctx_q.ext, ctx_q.rg};
    assign int_req_wdata = ctx_q.wdata;
    assign int_req_be    = ctx_q.be;
    assign hdr_valid     = (ctx_q.st == ST_HDR);
    assign hdr_type1     = ctx_q.t1;
    assign hdr_write     = ctx_q.wr;
    assign hdr_wdata     = ctx_q.wdata;
    assign hdr_be        = ctx_q.be;
    assign rsp_valid     = (ctx_q.st == ST_RESP);
    assign rsp_status    = ctx_q.status;
    assign rsp_rdata     = ctx_q.rdata;

    // R10: a single request in flight
    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R10: port reopens right after the response
    a_r10_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);
    // R11: stalled header must not move
    a_r11_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_bytes) && $stable(hdr_type1)));
    // R8: reserved header bits are zero
    a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> (hdr_bytes[15:12] == 4'h0 && hdr_bytes[1:0] == 2'b00));
    // R5: a Type 0 header only ever targets device 0
    a_r5_type0_dev0: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_type1) |-> (hdr_bytes[23:19] == 5'd0));
    // R7: aborted reads return all ones
    a_r7_abort_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == RS_MA && !ctx_q.wr) |-> (rsp_rdata == '1));
    // R13: response is a single-cycle pulse
    a_r13_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R9: no response while a forwarded request waits for its completion
    a_r9_wait_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_WAIT && !cpl_valid) |=> !rsp_valid);
endmodule

// File: tb/sim_cfg_route_top.sv
module sim_cfg_route_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_load = 1'b0;
    logic [7:0]  bus_sec_in = '0, bus_sub_in = '0;
    logic [31:0] int_dev_en = 32'hFFFF_FFFB;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [27:2] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ready;
    logic        int_req_valid, int_req_write;
    logic [4:0]  int_req_dev;
    logic [2:0]  int_req_fn;
    logic [9:0]  int_req_reg;
    logic [31:0] int_req_wdata;
    logic [3:0]  int_req_be;
    logic        int_cpl_valid = 1'b0;
    logic [31:0] int_cpl_rdata = '0;
    logic        hdr_valid, hdr_type1, hdr_write;
    logic        hdr_ready = 1'b0;
    logic [31:0] hdr_bytes, hdr_wdata;
    logic [3:0]  hdr_be;
    logic        cpl_valid = 1'b0, cpl_err = 1'b0;
    logic [31:0] cpl_rdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    cfg_route_top u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected <20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [27:2] mk(input logic [3:0] ext, input logic [7:0] bus,
                                       input logic [4:0] dev, input logic [2:0] fn, input logic [5:0] rg);
        return {ext, bus, dev, fn, rg};
    endfunction

    task automatic issue(input logic wr, input logic [27:2] a, input logic [31:0] wd, input logic [3:0] be);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready before issue", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic expect_abort(input logic wr, input logic [27:2] a, input string tag);
        issue(wr, a, 32'h1234_5678, 4'hF);
        @(negedge clk);
        chk(rsp_valid == 1'b1, {tag, " R13 abort rsp next cycle"}, {31'b0, rsp_valid}, 32'd1);
        chk(rsp_status == 2'd1, {tag, " R7 status MA"}, {30'b0, rsp_status}, 32'd1);
        chk(rsp_rdata == (wr ? 32'h0 : 32'hFFFF_FFFF), {tag, " R7 abort data"}, rsp_rdata,
            wr ? 32'h0 : 32'hFFFF_FFFF);
        chk(!hdr_valid && !int_req_valid, {tag, " R5 no header or internal req"},
            {30'b0, hdr_valid, int_req_valid}, 32'd0);
        @(negedge clk);
        chk(req_ready && !rsp_valid, {tag, " R10 ready again"}, {30'b0, req_ready, rsp_valid}, 32'd2);
    endtask

    task automatic fwd(input logic wr, input logic [7:0] bus, input logic [4:0] dev, input logic [2:0] fn,
                       input logic [5:0] rg, input logic [3:0] ext, input logic t1, input int stall,
                       input logic err, input logic [31:0] cdata, input string tag);
        logic [31:0] exp_hdr, exp_rd;
        exp_hdr = {bus, dev, fn, 4'h0, ext, rg, 2'b00};
        issue(wr, mk(ext, bus, dev, fn, rg), 32'hC0DE_0000 | {24'b0, bus}, 4'b0110);
        @(negedge clk);
        chk(hdr_valid == 1'b1, {tag, " R4/R6 header valid"}, {31'b0, hdr_valid}, 32'd1);
        chk(hdr_type1 == t1, {tag, " R4/R6 header type"}, {31'b0, hdr_type1}, {31'b0, t1});
        chk(hdr_bytes == exp_hdr, {tag, " R8 header bytes"}, hdr_bytes, exp_hdr);
        chk(hdr_write == wr, {tag, " R9 write flag"}, {31'b0, hdr_write}, {31'b0, wr});
        if (wr) chk(hdr_wdata == (32'hC0DE_0000 | {24'b0, bus}) && hdr_be == 4'b0110,
                    {tag, " R9 write payload"}, hdr_wdata, 32'hC0DE_0000 | {24'b0, bus});
        chk(req_ready == 1'b0, {tag, " R10 busy"}, {31'b0, req_ready}, 32'd0);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(hdr_valid && hdr_bytes == exp_hdr && hdr_type1 == t1, {tag, " R11 header held"},
                hdr_bytes, exp_hdr);
        end
        hdr_ready = 1'b1;
        @(posedge clk); #1;
        hdr_ready = 1'b0;
        @(negedge clk);
        chk(!hdr_valid, {tag, " R9 header taken"}, {31'b0, hdr_valid}, 32'd0);
        @(negedge clk);
        chk(!rsp_valid && !req_ready, {tag, " R9 waits for completion"},
            {30'b0, rsp_valid, req_ready}, 32'd0);
        cpl_valid = 1'b1; cpl_err = err; cpl_rdata = cdata;
        @(posedge clk); #1;
        cpl_valid = 1'b0; cpl_err = 1'b0;
        @(negedge clk);
        exp_rd = wr ? 32'h0 : (err ? 32'hFFFF_FFFF : cdata);
        chk(rsp_valid == 1'b1, {tag, " R13 rsp after completion"}, {31'b0, rsp_valid}, 32'd1);
        chk(rsp_status == (err ? 2'd2 : 2'd0), {tag, " R12 status"}, {30'b0, rsp_status},
            err ? 32'd2 : 32'd0);
        chk(rsp_rdata == exp_rd, {tag, " R12 data"}, rsp_rdata, exp_rd);
        chk(!req_ready, {tag, " R10 busy in rsp cycle"}, {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        chk(req_ready && !rsp_valid, {tag, " R10/R13 done"}, {30'b0, req_ready, rsp_valid}, 32'd2);
    endtask

    task automatic internal(input logic wr, input logic [4:0] dev, input logic [31:0] idata, input string tag);
        logic [31:0] exp_rd;
        issue(wr, mk(4'h3, 8'd0, dev, 3'd1, 6'h2A), 32'hFACE_0001, 4'b1001);
        @(negedge clk);
        chk(int_req_valid == 1'b1, {tag, " R2 internal req"}, {31'b0, int_req_valid}, 32'd1);
        chk(int_req_dev == dev && int_req_fn == 3'd1 && int_req_reg == {4'h3, 6'h2A},
            {tag, " R2 internal fields"}, {17'b0, int_req_dev, int_req_fn, int_req_reg? 10'h0 : 10'h0}, 32'd0);
        chk(int_req_write == wr && int_req_wdata == 32'hFACE_0001 && int_req_be == 4'b1001,
            {tag, " R2 internal payload"}, int_req_wdata, 32'hFACE_0001);
        chk(!hdr_valid, {tag, " R2 no header"}, {31'b0, hdr_valid}, 32'd0);
        @(negedge clk);
        chk(int_req_valid && !rsp_valid, {tag, " R2 held until done"}, {30'b0, int_req_valid, rsp_valid}, 32'd2);
        int_cpl_valid = 1'b1; int_cpl_rdata = idata;
        @(posedge clk); #1;
        int_cpl_valid = 1'b0;
        @(negedge clk);
        exp_rd = wr ? 32'h0 : idata;
        chk(rsp_valid && rsp_status == 2'd0, {tag, " R2/R13 ok rsp"}, {30'b0, rsp_status}, 32'd0);
        chk(rsp_rdata == exp_rd, {tag, " R2 data"}, rsp_rdata, exp_rd);
        @(negedge clk);
        chk(req_ready, {tag, " R10 ready"}, {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_reset;
        chk(req_ready && !hdr_valid && !int_req_valid && !rsp_valid, "R1 reset outputs",
            {28'b0, req_ready, hdr_valid, int_req_valid, rsp_valid}, 32'h8);
        expect_abort(1'b0, mk(4'h0, 8'd1, 5'd0, 3'd0, 6'd0), "R1 bus1 with zero range");
        expect_abort(1'b1, mk(4'h0, 8'd255, 5'd0, 3'd0, 6'd0), "R1 bus255 with zero range");
    endtask

    task automatic t_program;
        @(negedge clk);
        bus_load = 1'b1; bus_sec_in = 8'd3; bus_sub_in = 8'd7;
        @(posedge clk); #1;
        bus_load = 1'b0;
    endtask

    task automatic t_internal;
        internal(1'b0, 5'd0, 32'hA5A5_5A5A, "R2 read dev0");
        internal(1'b1, 5'd0, 32'h9999_9999, "R2 write dev0");
    endtask

    task automatic t_internal_missing;
        expect_abort(1'b0, mk(4'h0, 8'd0, 5'd1, 3'd0, 6'd4), "R3 absent dev1");
        expect_abort(1'b0, mk(4'h0, 8'd0, 5'd2, 3'd0, 6'd4), "R3 disabled dev2");
    endtask

    task automatic t_type0;
        fwd(1'b0, 8'd3, 5'd0, 3'd2, 6'h15, 4'hA, 1'b0, 0, 1'b0, 32'h0BAD_F00D, "R4 type0 read");
    endtask

    task automatic t_type0_bad_dev;
        expect_abort(1'b0, mk(4'h0, 8'd3, 5'd4, 3'd0, 6'd0), "R5 type0 dev4");
        expect_abort(1'b1, mk(4'h0, 8'd3, 5'd31, 3'd7, 6'd0), "R5 type0 dev31 write");
    endtask

    task automatic t_type1;
        fwd(1'b0, 8'd5, 5'd9, 3'd7, 6'h3F, 4'hF, 1'b1, 0, 1'b0, 32'h1357_9BDF, "R6 type1 mid");
        fwd(1'b0, 8'd7, 5'd0, 3'd0, 6'h00, 4'h0, 1'b1, 0, 1'b0, 32'h2468_ACE0, "R6 type1 top");
    endtask

    task automatic t_out_of_range;
        expect_abort(1'b0, mk(4'h0, 8'd8, 5'd0, 3'd0, 6'd0), "R7 bus above sub");
        expect_abort(1'b1, mk(4'h0, 8'd2, 5'd0, 3'd0, 6'd0), "R7 bus below sec write");
    endtask

    task automatic t_write_nonposted;
        fwd(1'b1, 8'd4, 5'd2, 3'd3, 6'h11, 4'hC, 1'b1, 0, 1'b0, 32'hDEAD_BEEF, "R9 ext write");
    endtask

    task automatic t_backpressure;
        fwd(1'b0, 8'd6, 5'd1, 3'd5, 6'h22, 4'h5, 1'b1, 3, 1'b0, 32'h0F0F_F0F0, "R11 stall");
    endtask

    task automatic t_cpl_err;
        fwd(1'b0, 8'd3, 5'd0, 3'd0, 6'h01, 4'h1, 1'b0, 0, 1'b1, 32'h1111_1111, "R12 error read");
        fwd(1'b1, 8'd6, 5'd3, 3'd0, 6'h01, 4'h1, 1'b1, 1, 1'b1, 32'h1111_1111, "R12 error write");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_program;
        t_internal;
        t_internal_missing;
        t_type0;
        t_type0_bad_dev;
        t_type1;
        t_out_of_range;
        t_write_nonposted;
        t_backpressure;
        t_cpl_err;
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule